// File: doc/BRIEF.md
# Staged Barrel Shifter with Sign Fill

This block is a purely combinational word shifter. A data word, a shift count and a two-bit operation code go in, and the shifted word comes out in the same settle time. It performs logical left shifts, logical right shifts and arithmetic right shifts.

The shift is built as a cascade of power-of-two stages. The stages move the word by 1, 2, 4, 8 and 16 positions, in that order. Each stage is switched on by its own bit of the shift count, starting from the least significant bit. The direction is decoded once, in front of the cascade.

Left shifts bring zeros in at the low end. Right shifts take their incoming bits from a fill word that is prepared before the first stage. The fill word holds copies of the sign bit for an arithmetic shift and zeros for a logical one. This lets a single right-shift path serve both kinds of right shift. The word width is a parameter and must be a power of two; the count width is derived from it.

Top module: `shf_log_shifter`

## Requirements
- R1: Operation code 2'b00 gives a logical left shift: the result equals the input shifted left by the count, with zeros in the vacated low positions.
- R2: Operation code 2'b10 gives a logical right shift: the result equals the input shifted right by the count, with zeros in the vacated high positions.
- R3: Operation code 2'b11 gives an arithmetic right shift: the vacated high positions take copies of input bit WIDTH-1.
- R4: Operation code 2'b01 behaves exactly like the logical right shift of code 2'b10.
- R5: A shift count of zero returns the input unchanged, whatever the operation code.
- R6: With a count of 31, an arithmetic right shift of an input whose bit 31 is set gives all ones. A logical right shift gives the former bit 31 in bit 0 and zeros elsewhere. A left shift gives the former bit 0 in bit 31 and zeros elsewhere.
- R7: The result follows its inputs with no clock and no stored state: any change of data, count or code is reflected in the output once the logic settles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shf_data_i | input | WIDTH (32) | Word to be shifted |
| shf_amt_i | input | log2(WIDTH) (5) | Shift count; bit n enables the 2^n stage |
| shf_op_i | input | 2 | Operation: 00 left logical, 01/10 right logical, 11 right arithmetic |
| shf_res_o | output | WIDTH (32) | Shifted word |

## Verification
Every result of this block is due in the same time step as its stimulus, because no register lies between any input and the output. The bench therefore applies a set of inputs, waits one nanosecond for the combinational logic to settle, and then samples. It never waits for a clock edge in order to see a result. The clock exists only to pace the watchdog. Some checks change the inputs several times within one clock period to show that the output never depends on an edge.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [1:0] {
      SHF_OP_SLL    = 2'b00,
      SHF_OP_SRL_LO = 2'b01,
      SHF_OP_SRL    = 2'b10,
      SHF_OP_SRA    = 2'b11
   } shf_op_e;

   typedef struct packed {
      logic to_left;
      logic arith;
   } shf_ctl_t;

   function automatic shf_ctl_t shf_decode(input logic [1:0] op);
      shf_ctl_t c;
      c.to_left = (op == SHF_OP_SLL);
      c.arith   = (op == SHF_OP_SRA);
      return c;
   endfunction

endpackage

// File: rtl/shf_fill_gen.sv
module shf_fill_gen #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] data_i,
   input  logic             arith_i,
   output logic [WIDTH-1:0] fill_o
);
   always_comb begin
      fill_o = arith_i ? {WIDTH{data_i[WIDTH-1]}} : '0;
   end
endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
   parameter int WIDTH = 32,
   parameter int DIST  = 1
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic [DIST-1:0]  fill_i,
   input  logic             en_i,
   input  logic             to_left_i,
   output logic [WIDTH-1:0] val_o
);
   initial begin
      if (DIST < 1 || DIST >= WIDTH)
         $error("shf_stage: DIST must lie in 1..WIDTH-1");
   end

   logic [WIDTH-1:0] moved_left;
   logic [WIDTH-1:0] moved_right;

   always_comb begin
      moved_left  = {val_i[WIDTH-1-DIST:0], {DIST{1'b0}}};
      moved_right = {fill_i, val_i[WIDTH-1:DIST]};
      if (!en_i)
         val_o = val_i;
      else if (to_left_i)
         val_o = moved_left;
      else
         val_o = moved_right;
   end
endmodule

// File: rtl/shf_log_shifter.sv
module shf_log_shifter
   import shf_pkg::*;
#(
   parameter int WIDTH = 32,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] shf_data_i,
   input  logic [AMT_W-1:0] shf_amt_i,
   input  logic [1:0]       shf_op_i,
   output logic [WIDTH-1:0] shf_res_o
);
   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         initial $error("shf_log_shifter: WIDTH must be a power of two, at least 2");
      end
   endgenerate

   shf_ctl_t         ctl;
   logic [WIDTH-1:0] fill;
   logic [AMT_W:0][WIDTH-1:0] chain;

   always_comb ctl = shf_decode(shf_op_i);

   shf_fill_gen #(.WIDTH(WIDTH)) fill_i (
      .data_i  (shf_data_i),
      .arith_i (ctl.arith),
      .fill_o  (fill)
   );

   assign chain[0] = shf_data_i;

   for (genvar s = 0; s < AMT_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      shf_stage #(.WIDTH(WIDTH), .DIST(DIST)) stage_i (
         .val_i     (chain[s]),
         .fill_i    (fill[DIST-1:0]),
         .en_i      (shf_amt_i[s]),
         .to_left_i (ctl.to_left),
         .val_o     (chain[s+1])
      );
   end

   assign shf_res_o = chain[AMT_W];
endmodule

// File: rtl/shf_log_shifter_chk.sv
module shf_log_shifter_chk #(
   parameter int WIDTH = 32,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] shf_data_i,
   input logic [AMT_W-1:0] shf_amt_i,
   input logic [1:0]       shf_op_i,
   input logic [WIDTH-1:0] shf_res_o
);
   logic [WIDTH-1:0] low_mask;
   logic [WIDTH-1:0] high_part;

   always_comb begin
      low_mask  = (WIDTH'(1) << shf_amt_i) - WIDTH'(1);
      high_part = shf_res_o >> (WIDTH - int'(shf_amt_i));

      AST_ZERO_PASS: assert (shf_amt_i != '0 || shf_res_o == shf_data_i); // R5
      AST_SLL_LOW_ZERO: assert (shf_op_i != 2'b00 || (shf_res_o & low_mask) == '0); // R1
      AST_SRL_HIGH_ZERO: assert (shf_op_i[1] == shf_op_i[0] || shf_amt_i == '0 || high_part == '0); // R2
      AST_SRA_SIGN_KEEP: assert (shf_op_i != 2'b11 || shf_res_o[WIDTH-1] == shf_data_i[WIDTH-1]); // R3
      AST_SRA_FULL_ONES: assert (shf_op_i != 2'b11 || shf_amt_i != '1 || !shf_data_i[WIDTH-1] || shf_res_o == '1); // R6
   end
endmodule

bind shf_log_shifter shf_log_shifter_chk #(.WIDTH(WIDTH)) chk_i (
   .shf_data_i (shf_data_i),
   .shf_amt_i  (shf_amt_i),
   .shf_op_i   (shf_op_i),
   .shf_res_o  (shf_res_o)
);

// File: tb/shf_log_shifter_tb_top.sv
`timescale 1ns/1ps
module shf_log_shifter_tb_top;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic [W-1:0]  data = '0;
   logic [4:0]    amt  = '0;
   logic [1:0]    op   = 2'b00;
   logic [W-1:0]  res;
   int            n_chk = 0;
   int            n_err = 0;
   bit            done  = 1'b0;

   always #2.5 clk = ~clk;

   shf_log_shifter #(.WIDTH(W)) dut_i (
      .shf_data_i (data),
      .shf_amt_i  (amt),
      .shf_op_i   (op),
      .shf_res_o  (res)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h (data=%h amt=%0d op=%b)", req, act, exp, data, amt, op);
      end
   endtask

   task automatic apply(input logic [W-1:0] d, input logic [4:0] a, input logic [1:0] o);
      data = d; amt = a; op = o;
      #1;
   endtask

   function automatic logic [W-1:0] pat(input int k);
      case (k)
         0: return 32'hDEAD_BEEF;
         1: return 32'h1234_5671;
         2: return 32'h8000_0001;
         default: return 32'h7FFF_FFFE;
      endcase
   endfunction

   task automatic t_reset_state;
      #1;
      check("R5 reset state", res, '0);
   endtask

   task automatic t_sll;
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 32; a++) begin
            apply(pat(k), 5'(a), 2'b00);
            check("R1 sll", res, pat(k) << a);
         end
   endtask

   task automatic t_srl;
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 32; a++) begin
            apply(pat(k), 5'(a), 2'b10);
            check("R2 srl", res, pat(k) >> a);
         end
   endtask

   task automatic t_sra;
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 32; a++) begin
            apply(pat(k), 5'(a), 2'b11);
            check("R3 sra", res, W'($signed(pat(k)) >>> a));
         end
   endtask

   task automatic t_op01;
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 32; a++) begin
            apply(pat(k), 5'(a), 2'b01);
            check("R4 op01 as srl", res, pat(k) >> a);
         end
   endtask

   task automatic t_zero_count;
      for (int o = 0; o < 4; o++)
         for (int k = 0; k < 4; k++) begin
            apply(pat(k), 5'd0, 2'(o));
            check("R5 zero count", res, pat(k));
         end
   endtask

   task automatic t_count31;
      apply(32'h8000_0000, 5'd31, 2'b11);
      check("R6 sra 31 neg", res, 32'hFFFF_FFFF);
      apply(32'h9234_5678, 5'd31, 2'b10);
      check("R6 srl 31", res, 32'h0000_0001);
      apply(32'h7FFF_FFFF, 5'd31, 2'b10);
      check("R6 srl 31 pos", res, 32'h0000_0000);
      apply(32'h0000_0003, 5'd31, 2'b00);
      check("R6 sll 31", res, 32'h8000_0000);
   endtask

   task automatic t_comb;
      @(negedge clk);
      apply(32'hF0F0_0000, 5'd4, 2'b11);
      check("R7 no clock 1", res, 32'hFF0F_0000);
      apply(32'hF0F0_0000, 5'd4, 2'b10);
      check("R7 no clock 2", res, 32'h0F0F_0000);
      apply(32'hF0F0_0000, 5'd4, 2'b00);
      check("R7 no clock 3", res, 32'h0F00_0000);
   endtask

   initial begin
      t_reset_state();
      t_sll();
      t_srl();
      t_sra();
      t_op01();
      t_zero_count();
      t_count31();
      t_comb();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule